// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block carries out the hardware side of taking an interrupt in a processor core. It samples a 3-bit encoded request level, filters out glitches and compares the result against the priority mask held in its own 16-bit status register. When a request wins, the block saves the status register as it stood and then changes the mode bits: it enters supervisor mode, switches tracing off and moves into interrupt state. It then pushes an exception frame of four halfwords through a single-word memory write port. Last, it raises a vector fetch request together with a one-cycle handler-start pulse.

The block keeps two stack pointers. One is the master stack, used while the core is in master state. The other is the interrupt stack. If the core is in master state when an interrupt is taken, the frame is written to the master stack first and a second copy goes to the interrupt stack. After that, the interrupt stack is the active one. An interrupt taken while the core is already in interrupt state writes one frame to the interrupt stack and nothing else. The execution path can overwrite the status register between entries, for example on a return from a handler.

Top module: `irq_entry_seq`

## Requirements
- R1: A request level counts only after it has been sampled equal on two consecutive rising edges. A level held for a single cycle is never taken. When a new level is taken, the first frame word is written in the cycle after the fourth rising edge that follows the level change.
- R2: A level L from 1 to 6 is taken only when L is greater than the mask field, status bits 10:8. Any level less than or equal to the mask is ignored, and level 0 never starts an entry.
- R3: Level 7 is non-maskable. It is taken on each rise of the qualified level to 7, even when the mask is 7. While level 7 is held, it is not taken a second time.
- R4: Taking a request sets bit 13 (supervisor) to 1, clears bit 15 (trace), clears bit 12 (master state) and loads the mask with the level taken. All other status bits keep their values.
- R5: A frame holds, from the lowest address up: the old status register at SP-8, PC[31:16] at SP-6, PC[15:0] at SP-4, and a format/vector word at SP-2. The format/vector word has the format in bits 15:12 and the vector number times 4 in bits 11:0. Words are written one per cycle, starting at the highest address, and the stack pointer then drops by 8.
- R6: If bit 12 of the old status register is 1, a format-0 frame is written to the master stack, followed by a format-1 copy on the interrupt stack. Both stack pointers drop by 8.
- R7: If bit 12 of the old status register is 0, one format-0 frame is written to the interrupt stack. The master stack pointer does not change.
- R8: In the cycle after the last frame word, handler_start and vec_req are both high for exactly one cycle, and vec_addr equals the vector number times 4.
- R9: A status load is applied at the next edge while the block is idle. A status load is ignored while an entry is in progress.
- R10: After reset, the status register reads 0x3700, the stack pointers hold their initial values, and no write or pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_level | input | 3 | Encoded interrupt request level (0 = none) |
| cur_pc | input | 32 | Program counter to save in the frame |
| vec_num | input | VEC_W | Vector number of the pending request |
| sr_load_en | input | 1 | Status register write from the execution path |
| sr_load_val | input | 16 | Value for the status register write |
| sr_q | output | 16 | Current status register |
| msp_q | output | 32 | Master stack pointer |
| isp_q | output | 32 | Interrupt stack pointer |
| mem_we | output | 1 | Stack word write strobe |
| mem_addr | output | 32 | Byte address of the stack word |
| mem_wdata | output | 16 | Stack word data |
| vec_req | output | 1 | Vector fetch request |
| vec_addr | output | 32 | Vector table offset for the fetch |
| handler_start | output | 1 | One-cycle handler start pulse |

## Verification
The case that is hardest to reach from the ports is a non-maskable request arriving while the mask is already 7, which happens right after an earlier level-7 entry. To reach it, the stimulus drops the level to 0 long enough for the filter to see the drop and then raises it to 7 again, so the second rise has to start a new entry. Holding the level high through the whole run shows that the held level is not taken a second time. Random status words cover every combination of trace, master state and mask, so the two-frame outer entry and the one-frame nested entry both appear many times. A status load placed in the middle of a push shows that the load is ignored while an entry is in progress.

// File: rtl/ienter_pkg.sv
package ienter_pkg;
    localparam int SR_W        = 16;
    localparam int LVL_W       = 3;
    localparam int WORD_W      = 16;
    localparam int PC_W        = 32;
    localparam int ADDR_W      = 32;
    localparam int FRAME_WORDS = 4;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam int VOFF_W      = 12;
    localparam int FMT_W       = 4;

    localparam int SR_T_BIT    = 15;
    localparam int SR_S_BIT    = 13;
    localparam int SR_M_BIT    = 12;
    localparam int SR_MASK_LO  = 8;

    localparam logic [FMT_W-1:0] FMT_PRIMARY = 4'h0;
    localparam logic [FMT_W-1:0] FMT_COPY    = 4'h1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [SR_W-1:0]   sr;
        logic [PC_W-1:0]   pc;
        logic [VOFF_W-1:0] voff;
    } frame_t;

    function automatic logic [LVL_W-1:0] sr_mask(input logic [SR_W-1:0] sr);
        return sr[SR_MASK_LO +: LVL_W];
    endfunction

    function automatic logic [SR_W-1:0] sr_enter(input logic [SR_W-1:0] sr,
                                                 input logic [LVL_W-1:0] lvl);
        logic [SR_W-1:0] n;
        n = sr;
        n[SR_T_BIT] = 1'b0;
        n[SR_S_BIT] = 1'b1;
        n[SR_M_BIT] = 1'b0;
        n[SR_MASK_LO +: LVL_W] = lvl;
        return n;
    endfunction

    function automatic logic [WORD_W-1:0] fvo_word(input logic [FMT_W-1:0] fmt,
                                                   input logic [VOFF_W-1:0] voff);
        return {fmt, voff};
    endfunction
endpackage

// File: rtl/ienter_lvl_qual.sv
module ienter_lvl_qual #(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] lvl_in,
    input  logic          nmi_clr,
    output logic [LW-1:0] qlvl,
    output logic          nmi_pend
);
    logic [LW-1:0] s1, s2;
    logic          agree;

    assign agree = (s1 == s2);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1       <= '0;
            s2       <= '0;
            qlvl     <= '0;
            nmi_pend <= 1'b0;
        end else begin
            s1 <= lvl_in;
            s2 <= s1;
            if (agree) begin
                qlvl <= s2;
            end
            if (agree && (&s2) && !(&qlvl)) begin
                nmi_pend <= 1'b1;
            end else if (nmi_clr) begin
                nmi_pend <= 1'b0;
            end
        end
    end

    // R1
    qual_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(qlvl) |-> ($past(lvl_in, 2) == $past(lvl_in, 3)) && (qlvl == $past(lvl_in, 3)));
endmodule

// File: rtl/ienter_prio.sv
module ienter_prio #(
    parameter int LW = 3
) (
    input  logic [LW-1:0] qlvl,
    input  logic          nmi_pend,
    input  logic [LW-1:0] mask,
    output logic          take,
    output logic [LW-1:0] take_lvl
);
    always_comb begin
        take     = nmi_pend || (qlvl > mask);
        take_lvl = nmi_pend ? {LW{1'b1}} : qlvl;
    end

    // R2
    always_comb begin
        zero_never_chk: assert (!(take && !nmi_pend && qlvl == '0));
    end
endmodule

// File: rtl/ienter_frame_word.sv
module ienter_frame_word
    import ienter_pkg::*;
(
    input  frame_t             fr,
    input  logic [IDX_W-1:0]   widx,
    input  logic [FMT_W-1:0]   fmt,
    input  logic [ADDR_W-1:0]  base,
    output logic [ADDR_W-1:0]  addr,
    output logic [WORD_W-1:0]  data
);
    logic [WORD_W-1:0] words [FRAME_WORDS];

    // Slot k sits at base - 2*(k+1); slot 0 is written first.
    assign words[0] = fvo_word(fmt, fr.voff);
    assign words[1] = fr.pc[WORD_W-1:0];
    assign words[2] = fr.pc[PC_W-1:WORD_W];
    assign words[3] = fr.sr;

    always_comb begin
        data = words[widx];
        addr = base - ADDR_W'({widx, 1'b0}) - ADDR_W'(2);
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import ienter_pkg::*;
#(
    parameter int               VEC_W    = 8,
    parameter logic [ADDR_W-1:0] MSP_INIT = 32'h0000_8000,
    parameter logic [ADDR_W-1:0] ISP_INIT = 32'h0000_4000,
    parameter logic [SR_W-1:0]   SR_INIT  = 16'h3700
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LVL_W-1:0]   irq_level,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [VEC_W-1:0]   vec_num,
    input  logic               sr_load_en,
    input  logic [SR_W-1:0]    sr_load_val,
    output logic [SR_W-1:0]    sr_q,
    output logic [ADDR_W-1:0]  msp_q,
    output logic [ADDR_W-1:0]  isp_q,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               vec_req,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic               handler_start
);
    localparam int                SP_STEP = 2 * FRAME_WORDS;
    localparam logic [IDX_W-1:0]  LAST_W  = IDX_W'(FRAME_WORDS - 1);

    seq_state_e        state;
    logic [IDX_W-1:0]  widx;
    logic              on_isp;
    logic              outer;
    frame_t            fr;
    logic              busy;

    logic [LVL_W-1:0]  qlvl;
    logic              nmi_pend;
    logic              nmi_clr;
    logic              take;
    logic [LVL_W-1:0]  take_lvl;
    logic              start;
    logic [FMT_W-1:0]  fmt;
    logic [ADDR_W-1:0] base;

    ienter_lvl_qual #(.LW(LVL_W)) qual_i (
        .clk      (clk),
        .rst      (rst),
        .lvl_in   (irq_level),
        .nmi_clr  (nmi_clr),
        .qlvl     (qlvl),
        .nmi_pend (nmi_pend)
    );

    ienter_prio #(.LW(LVL_W)) prio_i (
        .qlvl     (qlvl),
        .nmi_pend (nmi_pend),
        .mask     (sr_mask(sr_q)),
        .take     (take),
        .take_lvl (take_lvl)
    );

    assign busy    = (state != ST_IDLE);
    assign start   = (state == ST_IDLE) && !sr_load_en && take;
    assign nmi_clr = start && (&take_lvl);
    assign fmt     = (outer && on_isp) ? FMT_COPY : FMT_PRIMARY;
    assign base    = on_isp ? isp_q : msp_q;

    ienter_frame_word word_i (
        .fr   (fr),
        .widx (widx),
        .fmt  (fmt),
        .base (base),
        .addr (mem_addr),
        .data (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            widx   <= '0;
            on_isp <= 1'b0;
            outer  <= 1'b0;
            fr     <= '0;
            sr_q   <= SR_INIT;
            msp_q  <= MSP_INIT;
            isp_q  <= ISP_INIT;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sr_load_en) begin
                        sr_q <= sr_load_val;
                    end else if (take) begin
                        fr.sr   <= sr_q;
                        fr.pc   <= cur_pc;
                        fr.voff <= VOFF_W'({vec_num, 2'b00});
                        sr_q    <= sr_enter(sr_q, take_lvl);
                        outer   <= sr_q[SR_M_BIT];
                        on_isp  <= !sr_q[SR_M_BIT];
                        widx    <= '0;
                        state   <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    widx <= widx + 1'b1;
                    if (widx == LAST_W) begin
                        if (on_isp) begin
                            isp_q <= isp_q - ADDR_W'(SP_STEP);
                            state <= ST_DONE;
                        end else begin
                            msp_q  <= msp_q - ADDR_W'(SP_STEP);
                            on_isp <= 1'b1;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign mem_we        = (state == ST_PUSH);
    assign handler_start = (state == ST_DONE);
    assign vec_req       = (state == ST_DONE);
    assign vec_addr      = ADDR_W'(fr.voff);

    // R4
    enter_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> sr_q[SR_S_BIT] && !sr_q[SR_T_BIT] && !sr_q[SR_M_BIT]);

    // R2
    mask_raise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (sr_mask(sr_q) > $past(sr_mask(sr_q))) || (&sr_mask(sr_q)));

    // R9
    sr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(sr_q));

    // R5
    word_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we && (widx != '0) |-> mem_addr == $past(mem_addr) - ADDR_W'(2));

    // R8
    start_after_push_chk: assert property (@(posedge clk) disable iff (rst)
        handler_start |-> $past(mem_we) && !mem_we);

    // R7
    nested_msp_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !outer && $past(busy) |-> $stable(msp_q));
endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
    import ienter_pkg::*;

    localparam logic [31:0] MSP0 = 32'h0000_8000;
    localparam logic [31:0] ISP0 = 32'h0000_4000;
    localparam logic [15:0] SR0  = 16'h3700;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  irq_level = '0;
    logic [31:0] cur_pc = '0;
    logic [7:0]  vec_num = '0;
    logic        sr_load_en = 1'b0;
    logic [15:0] sr_load_val = '0;
    logic [15:0] sr_q;
    logic [31:0] msp_q, isp_q, mem_addr, vec_addr;
    logic        mem_we, vec_req, handler_start;
    logic [15:0] mem_wdata;

    int total = 0;
    int bad = 0;
    logic [15:0] m_sr;
    logic [31:0] m_msp, m_isp;

    always #2 clk = ~clk;

    irq_entry_seq dut_i (
        .clk(clk), .rst(rst), .irq_level(irq_level), .cur_pc(cur_pc),
        .vec_num(vec_num), .sr_load_en(sr_load_en), .sr_load_val(sr_load_val),
        .sr_q(sr_q), .msp_q(msp_q), .isp_q(isp_q), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .vec_req(vec_req),
        .vec_addr(vec_addr), .handler_start(handler_start)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_enter(input logic [15:0] sr, input logic [2:0] lvl);
        return (sr & ~16'h9700) | 16'h2000 | ({13'd0, lvl} << 8);
    endfunction

    task automatic load_sr(input logic [15:0] v);
        sr_load_en  = 1'b1;
        sr_load_val = v;
        @(negedge clk);
        sr_load_en = 1'b0;
        m_sr = v;
        chk(sr_q == v, "R9", "status load in idle", {16'd0, sr_q}, {16'd0, v});
    endtask

    task automatic run_case(input logic [2:0] lvl, input logic [31:0] pc,
                            input logic [7:0] vec, input bit poke);
        logic [31:0] wa [16];
        logic [15:0] wd [16];
        int          wc [16];
        int          nw, nhs, nvr, hs_c, n;
        logic [31:0] va;
        bit          take, outer;
        nw = 0; nhs = 0; nvr = 0; hs_c = -1; va = '0;
        take  = (lvl > m_sr[10:8]) || (lvl == 3'd7);
        outer = m_sr[12];
        irq_level = lvl;
        cur_pc    = pc;
        vec_num   = vec;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            if (mem_we) begin
                if (nw < 16) begin
                    wa[nw] = mem_addr;
                    wd[nw] = mem_wdata;
                    wc[nw] = c;
                end
                nw++;
            end
            if (handler_start) begin
                nhs++;
                hs_c = c;
                va = vec_addr;
            end
            if (vec_req) nvr++;
            if (poke && c == 6) begin
                sr_load_en  = 1'b1;
                sr_load_val = 16'hFFFF;
            end else begin
                sr_load_en = 1'b0;
            end
        end
        if (take) begin
            n = outer ? 8 : 4;
            chk(nw == n, outer ? "R6" : "R7", "frame word count", nw, n);
            for (int k = 0; k < n && k < nw; k++) begin
                logic [31:0] b, ea;
                logic [15:0] ed;
                logic [3:0]  f;
                int          j;
                j  = k % 4;
                b  = (outer && k < 4) ? m_msp : m_isp;
                f  = (outer && k >= 4) ? 4'h1 : 4'h0;
                ea = b - 32'(2 * (j + 1));
                case (j)
                    0: ed = {f, 12'({vec, 2'b00})};
                    1: ed = pc[15:0];
                    2: ed = pc[31:16];
                    default: ed = m_sr;
                endcase
                chk(wa[k] == ea, outer ? "R6" : "R7", "frame word address", wa[k], ea);
                chk(wd[k] == ed, "R5", "frame word data", {16'd0, wd[k]}, {16'd0, ed});
                chk(wc[k] == 4 + k, (k == 0) ? "R1" : "R5", "frame word cycle", wc[k], 4 + k);
            end
            chk(nhs == 1, (lvl == 3'd7) ? "R3" : "R8", "handler start count", nhs, 1);
            chk(nvr == 1, "R8", "vector request count", nvr, 1);
            chk(hs_c == 4 + n, "R8", "handler start cycle", hs_c, 4 + n);
            chk(va == {22'd0, vec, 2'b00}, "R8", "vector address", va, {22'd0, vec, 2'b00});
            if (outer) m_msp = m_msp - 32'd8;
            m_isp = m_isp - 32'd8;
            m_sr  = exp_enter(m_sr, lvl);
        end else begin
            chk(nw == 0, "R2", "masked level wrote frame", nw, 0);
            chk(nhs == 0, "R2", "masked level started handler", nhs, 0);
        end
        chk(sr_q == m_sr, poke ? "R9" : "R4", "status after entry", {16'd0, sr_q}, {16'd0, m_sr});
        chk(msp_q == m_msp, "R7", "master stack pointer", msp_q, m_msp);
        chk(isp_q == m_isp, "R6", "interrupt stack pointer", isp_q, m_isp);
        irq_level = 3'd0;
        repeat (5) @(negedge clk);
    endtask

    task automatic glitch_case(input logic [2:0] lvl);
        int nw;
        nw = 0;
        irq_level = lvl;
        @(negedge clk);
        irq_level = 3'd0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (mem_we || handler_start) nw++;
        end
        chk(nw == 0, "R1", "one-cycle level was taken", nw, 0);
        chk(sr_q == m_sr, "R1", "status after glitch", {16'd0, sr_q}, {16'd0, m_sr});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd24680);
        m_sr = SR0; m_msp = MSP0; m_isp = ISP0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sr_q == SR0, "R10", "reset status", {16'd0, sr_q}, {16'd0, SR0});
        chk(msp_q == MSP0, "R10", "reset master sp", msp_q, MSP0);
        chk(isp_q == ISP0, "R10", "reset interrupt sp", isp_q, ISP0);
        chk(!mem_we && !handler_start && !vec_req, "R10", "reset strobes",
            {29'd0, mem_we, handler_start, vec_req}, 32'd0);

        load_sr(16'h3000);
        run_case(3'd3, 32'h1234_5678, 8'h40, 1'b0);  // outer entry
        run_case(3'd5, 32'hCAFE_0102, 8'h19, 1'b0);  // nested entry
        run_case(3'd4, 32'h0000_1000, 8'h21, 1'b0);  // below mask
        run_case(3'd5, 32'h0000_2000, 8'h22, 1'b0);  // equal to mask
        run_case(3'd7, 32'hDEAD_BEE0, 8'h1F, 1'b0);  // R3 over mask 5
        run_case(3'd7, 32'h0BAD_F00C, 8'h1F, 1'b0);  // R3 with mask 7
        load_sr(16'hB000);
        run_case(3'd1, 32'h7654_3210, 8'hFF, 1'b0);  // trace cleared
        load_sr(16'h2000);
        run_case(3'd2, 32'h0000_ABCD, 8'h03, 1'b1);  // status load mid-push
        load_sr(16'h3000);
        glitch_case(3'd6);

        for (int i = 0; i < 40; i++) begin
            logic [15:0] s;
            logic [2:0]  l;
            logic [31:0] p;
            logic [7:0]  v;
            s = 16'($urandom);
            l = 3'($urandom);
            p = $urandom;
            v = 8'($urandom);
            load_sr(s);
            run_case(l, p, v, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule